// File: doc/BRIEF.md
# Strobed Serial Register Slave

This block is the slave end of a four-wire serial link that a host uses to read and write a small bank of 32-bit board-control registers. The lines are a serial clock, an active-low strobe, a data input and a data output. The link has no chip select. The host shifts bits in on rising serial-clock edges. It then marks the end of a command with a single serial-clock cycle in which the strobe is low. The level on the data input during that cycle picks the direction: 1 means write and 0 means read.

A write command sends the 32-bit data word first, then the 8-bit address. A read command sends only the 8-bit address. After a read strobe the host clocks the addressed word out on the data output. The block changes the data output on falling serial-clock edges, so each bit is stable before the host samples it just after a rising edge.

The bank has three general read/write words and a reset-control word. It also has two read-only words: the state of a set of DIP switches and a version word fixed by parameter. Writing a word with bit 0 set to the reset-control address drives a fixed-length board-reset pulse.

The block runs on a fast system clock. All host lines pass through synchroniser flops, and the block detects serial-clock edges in the system domain. The host clock must therefore be much slower than the system clock.

Top module: `bdctl_serial_slave`

## Requirements
- R1: While the synchronised strobe is high, each rising serial-clock edge shifts the data-input bit into a 40-bit window, newest bit at the least significant end. Fields travel most significant bit first. Bits older than the last 40 before a strobe are discarded.
- R2: A strobe cycle with data input 1 is a write. The write address is window bits [7:0] and the write data is window bits [39:8]. The strobe cycle itself is not shifted into the window.
- R3: A strobe cycle with data input 0 is a read of address window[7:0]. On each following falling serial-clock edge, ser_do_o presents the next bit of the addressed word, most significant first. The first falling edge presents bit 31. After 32 bits the output shows 0.
- R4: Addresses 0x00, 0x01 and 0x02 are 32-bit read/write registers. Each one returns the last word written to it.
- R5: Address 0x08 reads the synchronised DIP input, zero-extended to 32 bits. Address 0xFF reads the VERSION parameter. Writes to either address change nothing.
- R6: A read from any address that is not mapped returns 0. A write to such an address changes no register.
- R7: A write to 0x80 with bit 0 set drives board_rst_o high for exactly RST_PULSE system clocks. When the pulse ends, the register at 0x80 reads 0.
- R8: After reset, ser_do_o and board_rst_o are 0 and every read/write register reads 0.
- R9: A write to 0x80 with bit 0 clear stores the word, which then reads back, and produces no reset pulse.
- R10: The serial clock, strobe, data input and DIP input each pass through SYNC_STAGES flops. With SYNC_STAGES = 2, a serial-clock edge takes effect on the third system-clock edge after the pin changes, and ser_do_o updates on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock from host (idle low) |
| ser_stb_n_i | input | 1 | Active-low command strobe (idle high) |
| ser_di_i | input | 1 | Serial data from host (idle low) |
| ser_do_o | output | 1 | Serial read data to host |
| dip_i | input | DIP_W | DIP switch levels |
| board_rst_o | output | 1 | Board reset pulse, active high |

## Verification
The bench builds the block with DIP_W = 6. The zero-extension of the switch word into 32 bits is then visible in every DIP read. VERSION is set to a non-trivial pattern, so a read of the version word cannot pass by matching a reset value. SYNC_STAGES stays at 2 and RST_PULSE at 16. With these values, the exact cycle of every data-output change and the 16-clock length of the reset pulse can be compared against a reference model on every system clock.

// File: rtl/bdctl_pkg.sv
package bdctl_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned FRAME_W = WORD_W + ADDR_W;
  localparam int unsigned NUM_RW  = 3;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [FRAME_W-1:0] frame_t;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RW,
    SEL_DIP,
    SEL_RSTCTL,
    SEL_VER
  } sel_e;

  localparam addr_t ADR_DIP    = 8'h08;
  localparam addr_t ADR_RSTCTL = 8'h80;
  localparam addr_t ADR_VER    = 8'hFF;

  // Address of general read/write slot n.
  function automatic addr_t rw_addr(input int unsigned slot);
    case (slot)
      0:       return 8'h00;
      1:       return 8'h01;
      default: return 8'h02;
    endcase
  endfunction

  function automatic sel_e decode(input addr_t a);
    sel_e s;
    s = SEL_NONE;
    for (int unsigned i = 0; i < NUM_RW; i++)
      if (a == rw_addr(i)) s = SEL_RW;
    if (a == ADR_DIP)    s = SEL_DIP;
    if (a == ADR_RSTCTL) s = SEL_RSTCTL;
    if (a == ADR_VER)    s = SEL_VER;
    return s;
  endfunction

  // Field extraction from the capture window: address is the newest byte.
  function automatic addr_t frame_addr(input frame_t f);
    return f[ADDR_W-1:0];
  endfunction

  function automatic word_t frame_word(input frame_t f);
    return f[FRAME_W-1:ADDR_W];
  endfunction

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/bdctl_sync.sv
module bdctl_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < int'(STAGES); s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < int'(STAGES); s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/bdctl_frame.sv
module bdctl_frame
  import bdctl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sclk_s,
  input  logic  stb_n_s,
  input  logic  sdi_s,
  input  word_t rdata_i,
  output logic  wr_ev_o,
  output logic  rd_ev_o,
  output addr_t addr_o,
  output word_t wdata_o,
  output logic  sdo_o
);

  logic   sclk_q;
  logic   sclk_rise, sclk_fall;
  logic   strobe_ev, shift_ev;
  frame_t in_sh;
  word_t  out_sh;
  logic   sdo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_s;
  end

  assign sclk_rise = sclk_s & ~sclk_q;
  assign sclk_fall = ~sclk_s & sclk_q;
  assign strobe_ev = sclk_rise & ~stb_n_s;
  assign shift_ev  = sclk_rise & stb_n_s;
  assign wr_ev_o   = strobe_ev & sdi_s;
  assign rd_ev_o   = strobe_ev & ~sdi_s;

  // Capture window: oldest bits fall off the top.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        in_sh <= '0;
    else if (shift_ev) in_sh <= {in_sh[FRAME_W-2:0], sdi_s};
  end

  assign addr_o  = frame_addr(in_sh);
  assign wdata_o = frame_word(in_sh);

  // Read word is loaded on the read strobe and walked out on falling edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_sh <= '0;
      sdo_q  <= 1'b0;
    end else if (rd_ev_o) begin
      out_sh <= rdata_i;
    end else if (sclk_fall) begin
      sdo_q  <= out_sh[WORD_W-1];
      out_sh <= {out_sh[WORD_W-2:0], 1'b0};
    end
  end

  assign sdo_o = sdo_q;

  p_sdo_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_fall |=> $stable(sdo_q))
    else $error("data out changed without a falling serial edge");

  p_shift_on_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_rise |=> $stable(in_sh))
    else $error("capture window moved without a rising serial edge");

  p_strobe_no_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_ev |=> $stable(in_sh))
    else $error("strobe cycle was shifted into the window");

endmodule

// File: rtl/bdctl_regbank.sv
module bdctl_regbank
  import bdctl_pkg::*;
#(
  parameter int unsigned DIP_W     = 8,
  parameter int unsigned RST_PULSE = 16,
  parameter logic [31:0] VERSION   = 32'h0001_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ev_i,
  input  addr_t            addr_i,
  input  word_t            wdata_i,
  input  logic [DIP_W-1:0] dip_i,
  output word_t            rdata_o,
  output logic             board_rst_o
);

  localparam int unsigned CNT_W = cnt_width(RST_PULSE);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_PULSE);

  sel_e              sel;
  logic [NUM_RW-1:0] rw_wr;
  word_t             rw_q [NUM_RW];
  word_t             ctl_q;
  word_t             dip_word;
  logic [CNT_W-1:0]  cnt_q;
  logic              ctl_wr, pulse_go, pulse_last;

  assign sel = decode(addr_i);

  for (genvar g = 0; g < int'(NUM_RW); g++) begin : g_rw_hit
    assign rw_wr[g] = wr_ev_i && (addr_i == rw_addr(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(NUM_RW); i++) rw_q[i] <= '0;
    end else begin
      for (int i = 0; i < int'(NUM_RW); i++)
        if (rw_wr[i]) rw_q[i] <= wdata_i;
    end
  end

  assign ctl_wr     = wr_ev_i && (sel == SEL_RSTCTL);
  assign pulse_go   = ctl_wr && wdata_i[0];
  assign pulse_last = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (pulse_go)       cnt_q <= CNT_LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ctl_q <= '0;
    else if (ctl_wr)     ctl_q <= wdata_i;
    else if (pulse_last) ctl_q <= '0;
  end

  assign board_rst_o = (cnt_q != '0);
  assign dip_word    = WORD_W'(dip_i);

  always_comb begin
    rdata_o = '0;
    case (sel)
      SEL_RW: begin
        for (int unsigned i = 0; i < NUM_RW; i++)
          if (addr_i == rw_addr(i)) rdata_o = rw_q[i];
      end
      SEL_DIP:    rdata_o = dip_word;
      SEL_RSTCTL: rdata_o = ctl_q;
      SEL_VER:    rdata_o = VERSION;
      default:    rdata_o = '0;
    endcase
  end

  p_mode_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rw_wr[0] |=> $stable(rw_q[0]))
    else $error("slot 0 changed without a write to it");

  p_pulse_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(board_rst_o) |-> $past(pulse_go))
    else $error("board reset rose without a reset write");

  p_ctl_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(board_rst_o) |-> (ctl_q == '0))
    else $error("reset control not cleared at pulse end");

endmodule

// File: rtl/bdctl_serial_slave.sv
module bdctl_serial_slave
  import bdctl_pkg::*;
#(
  parameter int unsigned DIP_W       = 8,
  parameter int unsigned RST_PULSE   = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [31:0] VERSION     = 32'h0001_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk_i,
  input  logic             ser_stb_n_i,
  input  logic             ser_di_i,
  output logic             ser_do_o,
  input  logic [DIP_W-1:0] dip_i,
  output logic             board_rst_o
);

  // Line order inside the control synchroniser: {clock, strobe_n, data}.
  localparam logic [2:0] LINE_IDLE = 3'b010;

  logic [2:0]       line_s;
  logic [DIP_W-1:0] dip_s;
  logic             wr_ev, rd_ev;
  addr_t            addr;
  word_t            wdata, rdata;

  bdctl_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(LINE_IDLE)) u_line_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({ser_clk_i, ser_stb_n_i, ser_di_i}),
    .q_o   (line_s)
  );

  bdctl_sync #(.W(DIP_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_dip_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (dip_i),
    .q_o   (dip_s)
  );

  bdctl_frame u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk_s  (line_s[2]),
    .stb_n_s (line_s[1]),
    .sdi_s   (line_s[0]),
    .rdata_i (rdata),
    .wr_ev_o (wr_ev),
    .rd_ev_o (rd_ev),
    .addr_o  (addr),
    .wdata_o (wdata),
    .sdo_o   (ser_do_o)
  );

  bdctl_regbank #(.DIP_W(DIP_W), .RST_PULSE(RST_PULSE), .VERSION(VERSION)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_ev_i     (wr_ev),
    .addr_i      (addr),
    .wdata_i     (wdata),
    .dip_i       (dip_s),
    .rdata_o     (rdata),
    .board_rst_o (board_rst_o)
  );

  p_cmd_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ev |=> !wr_ev)
    else $error("write event directly after read event");

endmodule

// File: tb/bdctl_serial_slave_tb.sv
`timescale 1ns/1ps
module bdctl_serial_slave_tb;

  localparam int          DIP_W = 6;
  localparam int          PULSE = 16;
  localparam logic [31:0] VER   = 32'h5EC0_0A17;
  localparam int          HP    = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, stb_n = 1'b1, sdi = 1'b0;
  logic [DIP_W-1:0] dip = 6'h2D;
  logic sdo, brst;

  int compared = 0, mismatched = 0, brst_cycles = 0;
  bit run_cmp = 0;

  always #2.5 clk = ~clk;

  bdctl_serial_slave #(.DIP_W(DIP_W), .RST_PULSE(PULSE), .SYNC_STAGES(2), .VERSION(VER)) u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_stb_n_i(stb_n), .ser_di_i(sdi),
    .ser_do_o(sdo), .dip_i(dip), .board_rst_o(brst)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [39:0] m_sh;
  logic [31:0] m_out, m_mode, m_mux, m_vid, m_ctl;
  logic        m_sdo;
  int          m_cnt;
  logic        h_sclk [3];
  logic        h_stb  [3];
  logic        h_sdi  [3];
  logic [DIP_W-1:0] h_dip [3];

  function automatic logic [31:0] m_read(input logic [7:0] a, input logic [DIP_W-1:0] d);
    case (a)
      8'h00:   return m_mode;
      8'h01:   return m_mux;
      8'h02:   return m_vid;
      8'h08:   return 32'(d);
      8'h80:   return m_ctl;
      8'hFF:   return VER;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sh = '0; m_out = '0; m_sdo = 1'b0; m_cnt = 0;
      m_mode = '0; m_mux = '0; m_vid = '0; m_ctl = '0;
      for (int i = 0; i < 3; i++) begin
        h_sclk[i] = 1'b0; h_stb[i] = 1'b1; h_sdi[i] = 1'b0; h_dip[i] = '0;
      end
    end else begin
      // pin level seen two edges ago against the one before it
      if (m_cnt == 1) m_ctl = '0;
      if (m_cnt > 0)  m_cnt = m_cnt - 1;
      if (h_sclk[1] && !h_sclk[2]) begin
        if (!h_stb[1]) begin
          if (h_sdi[1]) begin
            case (m_sh[7:0])
              8'h00: m_mode = m_sh[39:8];
              8'h01: m_mux  = m_sh[39:8];
              8'h02: m_vid  = m_sh[39:8];
              8'h80: begin
                m_ctl = m_sh[39:8];
                if (m_sh[8]) m_cnt = PULSE;
              end
              default: ;
            endcase
          end else begin
            m_out = m_read(m_sh[7:0], h_dip[1]);
          end
        end else begin
          m_sh = {m_sh[38:0], h_sdi[1]};
        end
      end
      if (!h_sclk[1] && h_sclk[2]) begin
        m_sdo = m_out[31];
        m_out = {m_out[30:0], 1'b0};
      end
      for (int i = 2; i > 0; i--) begin
        h_sclk[i] = h_sclk[i-1]; h_stb[i] = h_stb[i-1];
        h_sdi[i]  = h_sdi[i-1];  h_dip[i] = h_dip[i-1];
      end
      h_sclk[0] = sclk; h_stb[0] = stb_n; h_sdi[0] = sdi; h_dip[0] = dip;
    end
  end

  // Cycle compare away from the active edge (R3, R7, R10).
  always @(negedge clk) begin
    if (rst_n && run_cmp) begin
      check("R3 R10", 32'(sdo), 32'(m_sdo), "ser_do per clock");
      check("R7 R10", 32'(brst), 32'(m_cnt != 0), "board_rst per clock");
      if (brst) brst_cycles++;
    end
  end

  // ---------------- host tasks ----------------
  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_bit(input logic b);
    sdi = b; wait_clk(HP);
    sclk = 1'b1; wait_clk(HP);
    sclk = 1'b0;
  endtask

  task automatic host_bits(input logic [63:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) host_bit(v[i]);
  endtask

  task automatic host_strobe(input logic w);
    sdi = w; stb_n = 1'b0; wait_clk(HP);
    sclk = 1'b1; wait_clk(HP);
    sclk = 1'b0; wait_clk(HP);
    stb_n = 1'b1; sdi = 1'b0; wait_clk(HP);
  endtask

  task automatic host_write(input logic [7:0] a, input logic [31:0] d);
    host_bits(64'(d), 32);
    host_bits(64'(a), 8);
    host_strobe(1'b1);
  endtask

  task automatic host_read(input logic [7:0] a, output logic [31:0] w);
    host_bits(64'(a), 8);
    host_strobe(1'b0);
    w = '0;
    for (int i = 0; i < 32; i++) begin
      sclk = 1'b1;
      w = {w[30:0], sdo};
      wait_clk(HP);
      sclk = 1'b0;
      wait_clk(HP);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog expired: actual 0x%08h expected 0x%08h", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] w;
    wait_clk(6);
    rst_n = 1'b1;
    run_cmp = 1;
    wait_clk(2);

    check("R8", 32'(sdo), 0, "ser_do after reset");
    check("R8", 32'(brst), 0, "board_rst after reset");
    host_read(8'h00, w); check("R8", w, 32'h0, "slot 0x00 after reset");
    host_read(8'h80, w); check("R8", w, 32'h0, "reset ctl after reset");

    host_write(8'h00, 32'hA5C3_0F1E);
    host_read(8'h00, w); check("R2", w, 32'hA5C3_0F1E, "write then read 0x00");
    host_write(8'h01, 32'h1234_5678);
    host_read(8'h01, w); check("R4", w, 32'h1234_5678, "read 0x01");
    host_write(8'h02, 32'h8000_0001);
    host_read(8'h02, w); check("R1", w, 32'h8000_0001, "MSB-first word 0x02");
    host_read(8'h00, w); check("R4", w, 32'hA5C3_0F1E, "0x00 kept");

    host_read(8'hFF, w); check("R5", w, VER, "version word");
    host_write(8'hFF, 32'h0);
    host_read(8'hFF, w); check("R5", w, VER, "version after write");
    host_read(8'h08, w); check("R5", w, 32'h0000_002D, "DIP zero-extended");
    host_write(8'h08, 32'hFFFF_FFFF);
    host_read(8'h08, w); check("R5", w, 32'h0000_002D, "DIP after write");
    dip = 6'h11;
    wait_clk(4);
    host_read(8'h08, w); check("R5", w, 32'h0000_0011, "DIP new value");

    host_read(8'h03, w); check("R6", w, 32'h0, "unmapped 0x03");
    host_write(8'h04, 32'hFFFF_FFFF);
    host_read(8'h04, w); check("R6", w, 32'h0, "unmapped 0x04 after write");
    host_read(8'h00, w); check("R6", w, 32'hA5C3_0F1E, "0x00 after unmapped write");
    host_read(8'h01, w); check("R6", w, 32'h1234_5678, "0x01 after unmapped write");

    host_write(8'h80, 32'h0000_0002);
    wait_clk(30);
    check("R9", 32'(brst_cycles), 0, "no pulse for bit0 clear");
    host_read(8'h80, w); check("R9", w, 32'h0000_0002, "reset ctl stored");

    host_write(8'h80, 32'h0000_0001);
    wait_clk(30);
    check("R7", 32'(brst_cycles), 32'(PULSE), "reset pulse length");
    host_read(8'h80, w); check("R7", w, 32'h0, "reset ctl cleared");

    host_bits(64'hFF, 8);
    host_write(8'h00, 32'h0F0F_3C3C);
    host_read(8'h00, w); check("R1", w, 32'h0F0F_3C3C, "overlong frame keeps last 40 bits");

    wait_clk(10);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule